// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models, in synthesizable form, the command interpreter inside a byte-wide parallel NOR flash. Each host write is a one-cycle strobe that carries an address and a data byte. The block decodes these strobes against a software lock. Unlock-protected sequences start one of four operations: byte program, sector erase, block erase or chip erase. Other sequences switch the read path into an identification view or a query view, or return it to the normal array view.

When a program or erase starts, a busy state is raised for a fixed number of clock cycles, set per operation type by parameters. The array update is applied as the busy state ends. While busy is high, every write is discarded. Reads are combinational from the shared address bus.

The storage is a small register array. Its physical byte is selected by `{addr[16:12], addr[2:0]}`: the sector number plus a three-bit offset, so address bits 11:3 alias within a sector. The array resets to all ones.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy` is 0, reads return the array, and every array byte reads FFh.
- R2: The writes AAh@5555h, then 55h@2AAAh, then A0h@5555h, then one write of data D at address A start a program of D at A. Unlock addresses are compared on `addr[15:0]`.
- R3: A program stores the old byte AND D, so it can only clear bits.
- R4: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, and then 30h at any address set to FFh every byte whose `addr[16:12]` matches that last address.
- R5: The same five-write prefix followed by 50h at any address sets to FFh every byte whose `addr[16]` matches that last address.
- R6: The same five-write prefix followed by 10h@5555h sets every array byte to FFh.
- R7: A write that does not match the next expected cycle of any sequence discards the partial sequence and returns reads to the array view. Its data is never stored.
- R8: While `busy` is 1, every write is ignored, including program, erase and exit sequences. The read view therefore does not change.
- R9: AAh@5555h, 55h@2AAAh, 90h@5555h enter the identification view. In that view, address 0 reads BFh, address 1 reads the `DEV_ID` parameter (default D8h), and any other address reads 00h.
- R10: AAh@5555h, 55h@2AAAh, 98h@5555h enter the query view. In that view, addresses 10h, 11h and 12h read 51h, 52h and 59h, and any other address reads 00h. AAh@5555h, 55h@2AAAh, F0h@5555h return reads to the array.
- R11: `busy` rises at the clock edge that accepts the final write of an operation. It stays high for exactly the per-type cycle count (program 8, sector 20, block 30, chip 40 by default). The array change becomes visible in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Shared address for writes and reads |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr` in the current view |
| busy | output | 1 | Internal program or erase in progress |

## Verification
Read data is combinational, so a new address is due in the same cycle. A view change from a third cycle shows one edge after that write. `busy` is due at the first falling-edge sample after the final write's rising edge. It holds for exactly the programmed number of samples, and the changed array bytes appear in the first sample where `busy` is low. The bench drives inputs just after the falling edge and advances its behavioural model on the rising edge. It compares `busy` and `rdata` at every falling edge, then adds directed reads and an exact busy-length count at these points.

// File: rtl/nor_pkg.sv
package nor_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_PGM, OP_SEC, OP_BLK, OP_CHIP} op_e;
  typedef enum logic [1:0] {MD_ARRAY, MD_ID, MD_CFI} mode_e;

  localparam logic [15:0] UNLOCK_A1 = 16'h5555;
  localparam logic [15:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0]  KEY1      = 8'hAA;
  localparam logic [7:0]  KEY2      = 8'h55;
  localparam logic [7:0]  CMD_PGM   = 8'hA0;
  localparam logic [7:0]  CMD_ERS   = 8'h80;
  localparam logic [7:0]  CMD_ID    = 8'h90;
  localparam logic [7:0]  CMD_CFI   = 8'h98;
  localparam logic [7:0]  CMD_EXIT  = 8'hF0;
  localparam logic [7:0]  CMD_SEC   = 8'h30;
  localparam logic [7:0]  CMD_BLK   = 8'h50;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  MFR_CODE  = 8'hBF;
endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] cmd_addr,
  input  logic [7:0]  wdata,
  input  logic        busy,
  output logic        op_start,
  output op_e         op_kind,
  output mode_e       mode
);
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3} seq_e;

  seq_e  seq_q, seq_d;
  mode_e mode_d;
  logic  at1, at2, bad;

  assign at1 = (cmd_addr == UNLOCK_A1);
  assign at2 = (cmd_addr == UNLOCK_A2);

  always_comb begin
    seq_d    = seq_q;
    mode_d   = mode;
    op_start = 1'b0;
    op_kind  = OP_NONE;
    bad      = 1'b0;
    if (wr_en && !busy) begin
      seq_d = S_IDLE;
      bad   = 1'b1;
      case (seq_q)
        S_IDLE: if (at1 && wdata == KEY1) begin seq_d = S_U1; bad = 1'b0; end
        S_U1:   if (at2 && wdata == KEY2) begin seq_d = S_U2; bad = 1'b0; end
        S_U2: if (at1) begin
          bad = 1'b0;
          case (wdata)
            CMD_PGM:  seq_d  = S_PGM;
            CMD_ERS:  seq_d  = S_E1;
            CMD_ID:   mode_d = MD_ID;
            CMD_CFI:  mode_d = MD_CFI;
            CMD_EXIT: mode_d = MD_ARRAY;
            default:  bad    = 1'b1;
          endcase
        end
        S_PGM: begin
          bad      = 1'b0;
          op_start = 1'b1;
          op_kind  = OP_PGM;
        end
        S_E1: if (at1 && wdata == KEY1) begin seq_d = S_E2; bad = 1'b0; end
        S_E2: if (at2 && wdata == KEY2) begin seq_d = S_E3; bad = 1'b0; end
        S_E3: begin
          if (wdata == CMD_SEC) begin
            bad = 1'b0; op_start = 1'b1; op_kind = OP_SEC;
          end else if (wdata == CMD_BLK) begin
            bad = 1'b0; op_start = 1'b1; op_kind = OP_BLK;
          end else if (wdata == CMD_CHIP && at1) begin
            bad = 1'b0; op_start = 1'b1; op_kind = OP_CHIP;
          end
        end
        default: bad = 1'b1;
      endcase
      if (bad) mode_d = MD_ARRAY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= S_IDLE;
      mode  <= MD_ARRAY;
    end else begin
      seq_q <= seq_d;
      mode  <= mode_d;
    end
  end
endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
  import nor_pkg::*;
#(
  parameter int PGM_CYC  = 8,
  parameter int SEC_CYC  = 20,
  parameter int BLK_CYC  = 30,
  parameter int CHIP_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_start,
  input  op_e  op_kind,
  output logic busy,
  output logic commit
);
  localparam int MAX_AB = (PGM_CYC > SEC_CYC) ? PGM_CYC : SEC_CYC;
  localparam int MAX_CD = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             busy_d;

  always_comb begin
    case (op_kind)
      OP_PGM:  len = CNT_W'(PGM_CYC - 1);
      OP_SEC:  len = CNT_W'(SEC_CYC - 1);
      OP_BLK:  len = CNT_W'(BLK_CYC - 1);
      OP_CHIP: len = CNT_W'(CHIP_CYC - 1);
      default: len = '0;
    endcase
  end

  assign commit = busy && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (op_start) begin
      busy_d = 1'b1;
      cnt_d  = len;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/nor_array.sv
module nor_array
  import nor_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OFS_W  = 3,
  parameter int BSEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  op_e              op_kind,
  input  logic [IDX_W-1:0] op_idx,
  input  logic [7:0]       op_data,
  input  logic             commit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int BLK_L = OFS_W + BSEC_W;

  op_e              kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       data_q;
  logic [7:0]       cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OP_NONE;
      idx_q  <= '0;
      data_q <= '0;
    end else if (op_start) begin
      kind_q <= op_kind;
      idx_q  <= op_idx;
      data_q <= op_data;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [IDX_W-1:0] ME = IDX_W'(i);
    logic [7:0] cell_q, cell_d;
    logic       hit;

    always_comb begin
      case (kind_q)
        OP_PGM:  hit = (ME == idx_q);
        OP_SEC:  hit = (ME[IDX_W-1:OFS_W] == idx_q[IDX_W-1:OFS_W]);
        OP_BLK:  hit = (ME[IDX_W-1:BLK_L] == idx_q[IDX_W-1:BLK_L]);
        OP_CHIP: hit = 1'b1;
        default: hit = 1'b0;
      endcase
      cell_d = cell_q;
      if (commit && hit) cell_d = (kind_q == OP_PGM) ? (cell_q & data_q) : 8'hFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= 8'hFF;
      else        cell_q <= cell_d;
    end

    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_idx];
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_pkg::*;
#(
  parameter int         ADDR_W   = 17,
  parameter int         SECT_LSB = 12,
  parameter int         BLK_LSB  = 16,
  parameter int         OFS_W    = 3,
  parameter logic [7:0] DEV_ID   = 8'hD8,
  parameter int         PGM_CYC  = 8,
  parameter int         SEC_CYC  = 20,
  parameter int         BLK_CYC  = 30,
  parameter int         CHIP_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int IDX_W  = ADDR_W - SECT_LSB + OFS_W;
  localparam int BSEC_W = BLK_LSB - SECT_LSB;

  logic             op_start, commit;
  op_e              op_kind;
  mode_e            mode;
  logic [IDX_W-1:0] idx;
  logic [7:0]       arr_data;

  assign idx = {addr[ADDR_W-1:SECT_LSB], addr[OFS_W-1:0]};

  nor_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd_addr(addr[15:0]),
    .wdata(wdata), .busy(busy), .op_start(op_start), .op_kind(op_kind),
    .mode(mode)
  );

  nor_op_timer #(
    .PGM_CYC(PGM_CYC), .SEC_CYC(SEC_CYC), .BLK_CYC(BLK_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .busy(busy), .commit(commit)
  );

  nor_array #(.IDX_W(IDX_W), .OFS_W(OFS_W), .BSEC_W(BSEC_W)) u_array (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_idx(idx), .op_data(wdata), .commit(commit), .rd_idx(idx),
    .rd_data(arr_data)
  );

  always_comb begin
    rdata = arr_data;
    if (mode == MD_ID) begin
      if (addr == ADDR_W'(0))      rdata = MFR_CODE;
      else if (addr == ADDR_W'(1)) rdata = DEV_ID;
      else                         rdata = 8'h00;
    end else if (mode == MD_CFI) begin
      if (addr == ADDR_W'(16'h10))      rdata = 8'h51;
      else if (addr == ADDR_W'(16'h11)) rdata = 8'h52;
      else if (addr == ADDR_W'(16'h12)) rdata = 8'h59;
      else                              rdata = 8'h00;
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk
  import nor_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              op_start,
  input logic              commit,
  input mode_e             mode,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata
);
  a_r11_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy);

  a_r11_commit_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  a_r11_commit_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  a_r8_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_start);

  a_r8_view_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode));

  a_r9_maker_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ID && addr == ADDR_W'(0)) |-> rdata == 8'hBF);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .op_start(op_start),
  .commit(commit), .mode(mode), .addr(addr), .rdata(rdata)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;
  localparam int AW = 17, PGM = 8, SEC = 20, BLK = 30, CHIP = 40;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;

  int    total = 0, bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  nor_cmd_seq #(.ADDR_W(AW), .PGM_CYC(PGM), .SEC_CYC(SEC), .BLK_CYC(BLK),
                .CHIP_CYC(CHIP)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy));

  // behavioural reference model
  logic [7:0] m_mem [256];
  int m_seq, m_view, m_bcnt, m_kind, m_tidx;
  logic [7:0] m_tdat;
  bit ok, a1, a2;

  function automatic int ix(logic [AW-1:0] a);
    return int'({a[16:12], a[2:0]});
  endfunction

  function automatic logic [7:0] m_read(logic [AW-1:0] a);
    if (m_view == 1) return (a == 0) ? 8'hBF : (a == 1) ? 8'hD8 : 8'h00;
    if (m_view == 2) return (a == 'h10) ? 8'h51 : (a == 'h11) ? 8'h52 :
                            (a == 'h12) ? 8'h59 : 8'h00;
    return m_mem[ix(a)];
  endfunction

  task automatic m_start(int kind, int len);
    m_kind = kind; m_tidx = ix(addr); m_tdat = wdata; m_bcnt = len;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[j]) m_mem[j] = 8'hFF;
      m_seq = 0; m_view = 0; m_bcnt = 0; m_kind = 0;
    end else if (m_bcnt > 0) begin
      m_bcnt--;
      if (m_bcnt == 0) begin
        for (int j = 0; j < 256; j++) begin
          if (m_kind == 1 && j == m_tidx)                m_mem[j] = m_mem[j] & m_tdat;
          else if (m_kind == 2 && (j >> 3) == (m_tidx >> 3)) m_mem[j] = 8'hFF;
          else if (m_kind == 3 && (j >> 7) == (m_tidx >> 7)) m_mem[j] = 8'hFF;
          else if (m_kind == 4)                          m_mem[j] = 8'hFF;
        end
      end
    end else if (wr_en) begin
      a1 = (addr[15:0] == 16'h5555);
      a2 = (addr[15:0] == 16'h2AAA);
      ok = 1'b0;
      case (m_seq)
        0: begin ok = a1 && wdata == 8'hAA; m_seq = ok ? 1 : 0; end
        1: begin ok = a2 && wdata == 8'h55; m_seq = ok ? 2 : 0; end
        2: begin
          m_seq = 0;
          if (a1) begin
            ok = 1'b1;
            if (wdata == 8'hA0)      m_seq = 3;
            else if (wdata == 8'h80) m_seq = 4;
            else if (wdata == 8'h90) m_view = 1;
            else if (wdata == 8'h98) m_view = 2;
            else if (wdata == 8'hF0) m_view = 0;
            else ok = 1'b0;
          end
        end
        3: begin ok = 1'b1; m_seq = 0; m_start(1, PGM); end
        4: begin ok = a1 && wdata == 8'hAA; m_seq = ok ? 5 : 0; end
        5: begin ok = a2 && wdata == 8'h55; m_seq = ok ? 6 : 0; end
        default: begin
          m_seq = 0; ok = 1'b1;
          if (wdata == 8'h30)            m_start(2, SEC);
          else if (wdata == 8'h50)       m_start(3, BLK);
          else if (wdata == 8'h10 && a1) m_start(4, CHIP);
          else ok = 1'b0;
        end
      endcase
      if (!ok) m_view = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (busy !== (m_bcnt > 0)) begin
        bad++;
        $display("FAIL %s busy got=%0b exp=%0b", cur_req, busy, m_bcnt > 0);
      end
      total++;
      if (rdata !== m_read(addr)) begin
        bad++;
        $display("FAIL %s rdata@%h got=%h exp=%h", cur_req, addr, rdata, m_read(addr));
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic unlock(logic [7:0] cmd);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, cmd);
  endtask

  task automatic erase(logic [AW-1:0] a, logic [7:0] cmd);
    unlock(8'h80); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(a, cmd);
  endtask

  task automatic settle();
    repeat (CHIP + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 busy", {7'd0, busy}, 8'h00);
    rd(17'h00123, v); chk("R1 erased", v, 8'hFF);

    // R2 / R11 program and busy length
    cur_req = "R2";
    unlock(8'hA0); wr(17'h00123, 8'h5A);
    @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R11 program busy length", 8'(n), 8'(PGM));
    chk("R11 data at busy fall", rdata, 8'h5A);
    rd(17'h00123, v); chk("R2 programmed", v, 8'h5A);

    // R3 AND behaviour
    cur_req = "R3";
    unlock(8'hA0); wr(17'h00123, 8'hF0); settle();
    rd(17'h00123, v); chk("R3 and", v, 8'h50);

    cur_req = "R2";
    unlock(8'hA0); wr(17'h1F001, 8'h33); settle();
    unlock(8'hA0); wr(17'h0F002, 8'h44); settle();
    unlock(8'hA0); wr(17'h0E002, 8'h55); settle();
    rd(17'h1F001, v); chk("R2 high block", v, 8'h33);

    // R4 sector erase, with R8 writes during busy
    cur_req = "R4";
    erase(17'h0F7FF, 8'h30);
    cur_req = "R8";
    unlock(8'hA0); wr(17'h0E002, 8'h00);
    settle();
    rd(17'h0F002, v); chk("R4 sector cleared", v, 8'hFF);
    rd(17'h0E002, v); chk("R4/R8 neighbour kept", v, 8'h55);

    // R7 abort
    cur_req = "R7";
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h77);
    wr(17'h0E002, 8'h00);
    @(negedge clk);
    chk("R7 not busy", {7'd0, busy}, 8'h00);
    rd(17'h0E002, v); chk("R7 no store", v, 8'h55);
    unlock(8'h90); wr(17'h00000, 8'h12);
    rd(17'h00000, v); chk("R7 view back to array", v, 8'hFF);

    // R5 block erase
    cur_req = "R5";
    erase(17'h10000, 8'h50); settle();
    rd(17'h1F001, v); chk("R5 block cleared", v, 8'hFF);
    rd(17'h00123, v); chk("R5 other block kept", v, 8'h50);

    // R9 identification view
    cur_req = "R9";
    unlock(8'h90);
    rd(17'h00000, v); chk("R9 maker", v, 8'hBF);
    rd(17'h00001, v); chk("R9 device", v, 8'hD8);
    rd(17'h00002, v); chk("R9 other", v, 8'h00);

    // R8 exit ignored while busy
    cur_req = "R8";
    unlock(8'hA0); wr(17'h00005, 8'h0F);
    unlock(8'hF0);
    settle();
    rd(17'h00000, v); chk("R8 exit ignored", v, 8'hBF);

    // R10 query view and exit
    cur_req = "R10";
    unlock(8'h98);
    rd(17'h00010, v); chk("R10 q", v, 8'h51);
    rd(17'h00011, v); chk("R10 r", v, 8'h52);
    rd(17'h00012, v); chk("R10 y", v, 8'h59);
    unlock(8'hF0);
    rd(17'h00005, v); chk("R10 exit to array", v, 8'h0F);

    // R6 chip erase
    cur_req = "R6";
    erase(17'h05555, 8'h10); settle();
    rd(17'h00123, v); chk("R6 chip cleared", v, 8'hFF);
    rd(17'h0E002, v); chk("R6 chip cleared 2", v, 8'hFF);

    finish_run();
  end
endmodule